// File: doc/BRIEF.md
# Dual Packed Event Counter Unit

This block counts processor events on two 32-bit counters that software reaches as one 64-bit count register. A 64-bit control register holds a six-bit event selector for each counter, a single set of privilege enables (user, supervisor, hypervisor) that gates both counters together, and an interrupt enable. Each counter picks one line from a 64-line event vector. Code 0 is wired to count every clock. Code k for any other value counts when line k is high.

Counting cannot be stopped on one counter alone, because both counters share the privilege enables. Software therefore parks an unused counter on a reserved code that never advances it. A counter that steps from all ones to zero sets its own sticky overflow flag. The interrupt output is high while any flag is set and interrupts are enabled. Software arms a counter by loading it with the negated sample period. Half-register write strobes let one counter be loaded while the other keeps counting.

Top module: `dual_evt_ctr`

## Requirements
- R1: After reset the control, count and status registers all read 0 and `irq` is low.
- R2: In the count register (address 1), counter 0 occupies bits 63:32 and counter 1 occupies bits 31:0. A value written with both strobes set reads back exactly while no counting is enabled.
- R3: When a counter steps from 0xFFFFFFFF, it becomes 0 on the next clock and its sticky flag in the status register (address 2) is set. Bit 0 is counter 0 and bit 1 is counter 1. Just after the wrap, bit 31 of the count is clear.
- R4: Control bits 1, 2 and 3 enable counting in user, supervisor and hypervisor context. These bits apply to both counters at once. `priv` is 0 for user, 1 for supervisor, 2 for hypervisor and 3 for no context. A counter advances only when the enable bit for the current `priv` is set. With bits 3:1 clear, neither counter moves.
- R5: The selector for counter 0 is control bits 16:11 and the selector for counter 1 is control bits 9:4. Code 0 counts every enabled clock. Any other code k counts on enabled clocks where `evt_in[k]` is high.
- R6: Code 0x1C on counter 0 and code 0x14 on counter 1 never advance that counter, whatever `evt_in` holds. Each code is reserved only on its own counter.
- R7: `reg_wstrb[1]` enables a write to counter 0 and `reg_wstrb[0]` enables a write to counter 1. A counter whose strobe is clear keeps its value or keeps counting.
- R8: If a count-register write and an increment reach the same counter in the same clock, the written value is stored.
- R9: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. If a wrap and a clear coincide, the flag stays set.
- R10: `irq` equals control bit 0 ANDed with the OR of the two status flags.
- R11: A counter advances by at most one per clock. Code 0 held for N enabled clocks adds exactly N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 counts, 2 status, 3 reads 0 |
| reg_wstrb | input | 2 | Count-register half enables: bit 1 upper, bit 0 lower |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| evt_in | input | 64 | Event lines, one per selector code |
| priv | input | 2 | Current context: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong selector decode, a wrong privilege decode or a wrong park decode makes a counter advance by the wrong amount. The error shows at the next count-register read after an enabled window of known length. A broken half-write mask corrupts the other counter, and this is visible on the read that immediately follows the write. Wrap-detection and flag faults appear on `irq` and in the status register one clock after the step from all ones. This is why the bench counts windows exactly and reads back after each one.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSVD = 2'd3
  } addr_e;

  localparam int CTL_IRQ_BIT = 0;
  localparam int CTL_USR_BIT = 1;
  localparam int CTL_SUP_BIT = 2;
  localparam int CTL_HYP_BIT = 3;

  // true when the enable for the present context is set
  function automatic logic ctx_allows(input logic [1:0] priv,
                                      input logic usr_en,
                                      input logic sup_en,
                                      input logic hyp_en);
    logic ok;
    case (priv)
      PRIV_USER: ok = usr_en;
      PRIV_SUP:  ok = sup_en;
      PRIV_HYP:  ok = hyp_en;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/dpc_ctx_gate.sv
module dpc_ctx_gate
  import dpc_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       usr_en,
  input  logic       sup_en,
  input  logic       hyp_en,
  output logic       ctx_ok
);
  always_comb ctx_ok = ctx_allows(priv, usr_en, sup_en, hyp_en);
endmodule

// File: rtl/dpc_evt_sel.sv
module dpc_evt_sel #(
  parameter int SEL_W     = 6,
  parameter int PARK_CODE = 28,
  localparam int NEVT     = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] code,
  input  logic [NEVT-1:0]  evt_in,
  output logic             hit
);
  localparam logic [SEL_W-1:0] PARK = SEL_W'(PARK_CODE);

  always_comb begin
    if (code == '0)
      hit = 1'b1;            // cycle count
    else if (code == PARK)
      hit = 1'b0;            // parked counter stays idle
    else
      hit = evt_in[code];
  end
endmodule

// File: rtl/dpc_counter.sv
module dpc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             flag_q
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  assign wrap = step_en && !load_en && at_top(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load_en)      cnt_q <= load_val;
      else if (step_en) cnt_q <= bump(cnt_q);
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_evt_ctr.sv
module dual_evt_ctr
  import dpc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SEL_W      = 6,
  parameter int UP_SEL_LSB = 11,
  parameter int LO_SEL_LSB = 4,
  parameter int UP_PARK    = 28,
  parameter int LO_PARK    = 20,
  localparam int REG_W     = 2 * CNT_W,
  localparam int NEVT      = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [1:0]       reg_wstrb,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NEVT-1:0]  evt_in,
  input  logic [1:0]       priv,
  output logic             irq
);
  logic [REG_W-1:0]          ctrl_q;
  logic [1:0][CNT_W-1:0]     cnt_q;
  logic [1:0]                cnt_step;
  logic [1:0]                cnt_load;
  logic [1:0]                cnt_wrap;
  logic [1:0]                ovf_flag;
  logic [1:0]                flag_clr;
  logic [1:0]                evt_hit;
  logic                      ctx_ok;

  wire wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  wire wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
  wire wr_stat = reg_wr && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata;
  end

  dpc_ctx_gate u_gate (
    .priv   (priv),
    .usr_en (ctrl_q[CTL_USR_BIT]),
    .sup_en (ctrl_q[CTL_SUP_BIT]),
    .hyp_en (ctrl_q[CTL_HYP_BIT]),
    .ctx_ok (ctx_ok)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    localparam int DAT_LSB = (i == 0) ? CNT_W : 0;
    localparam int SEL_LSB = (i == 0) ? UP_SEL_LSB : LO_SEL_LSB;
    localparam int PARK    = (i == 0) ? UP_PARK : LO_PARK;
    localparam int STRB    = 1 - i;

    dpc_evt_sel #(.SEL_W(SEL_W), .PARK_CODE(PARK)) u_sel (
      .code   (ctrl_q[SEL_LSB +: SEL_W]),
      .evt_in (evt_in),
      .hit    (evt_hit[i])
    );

    assign cnt_step[i] = ctx_ok && evt_hit[i];
    assign cnt_load[i] = wr_cnt && reg_wstrb[STRB];
    assign flag_clr[i] = wr_stat && reg_wdata[i];

    dpc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (cnt_step[i]),
      .load_en  (cnt_load[i]),
      .load_val (reg_wdata[DAT_LSB +: CNT_W]),
      .flag_clr (flag_clr[i]),
      .cnt_q    (cnt_q[i]),
      .wrap     (cnt_wrap[i]),
      .flag_q   (ovf_flag[i])
    );
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_CNT:  reg_rdata = {cnt_q[0], cnt_q[1]};
      ADDR_STAT: reg_rdata = {{(REG_W-2){1'b0}}, ovf_flag};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = ctrl_q[CTL_IRQ_BIT] && (|ovf_flag);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int CNT_W      = 32,
  parameter int SEL_W      = 6,
  parameter int UP_SEL_LSB = 11,
  parameter int LO_SEL_LSB = 4,
  parameter int UP_PARK    = 28,
  parameter int LO_PARK    = 20,
  localparam int REG_W     = 2 * CNT_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [REG_W-1:0]      ctrl_q,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [1:0]            cnt_step,
  input logic [1:0]            cnt_load,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [1:0]            ovf_flag,
  input logic                  irq
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    localparam int DAT_LSB = (i == 0) ? CNT_W : 0;
    localparam int SEL_LSB = (i == 0) ? UP_SEL_LSB : LO_SEL_LSB;
    localparam logic [SEL_W-1:0] PARK = SEL_W'((i == 0) ? UP_PARK : LO_PARK);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load[i] |=> cnt_q[i] == $past(reg_wdata[DAT_LSB +: CNT_W]));

    assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_load[i] && cnt_step[i] && (&cnt_q[i])) |=> (cnt_q[i] == '0) && ovf_flag[i]);

    assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_load[i] |=> (cnt_q[i] == $past(cnt_q[i])) ||
                       (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));

    assert_ctx_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:1] == 3'b000 && !cnt_load[i]) |=> $stable(cnt_q[i]));

    assert_parked_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[SEL_LSB +: SEL_W] == PARK && !cnt_load[i]) |=> $stable(cnt_q[i]));
  end

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !irq);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf_flag));
endmodule

bind dual_evt_ctr dpc_checker #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .UP_SEL_LSB(UP_SEL_LSB),
  .LO_SEL_LSB(LO_SEL_LSB), .UP_PARK(UP_PARK), .LO_PARK(LO_PARK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .cnt_step  (cnt_step),
  .cnt_load  (cnt_load),
  .reg_wdata (reg_wdata),
  .ovf_flag  (ovf_flag),
  .irq       (irq)
);

// File: tb/dual_evt_ctr_test.sv
module dual_evt_ctr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [1:0]  reg_wstrb = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [63:0] evt_in = '0;
  logic [1:0]  priv = 2'd3;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_evt_ctr uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .priv(priv), .irq(irq)
  );

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_STAT = 2'd2;

  function automatic logic [63:0] mk_ctrl(input bit ie, input bit u, input bit s,
                                          input bit h, input logic [5:0] up,
                                          input logic [5:0] lo);
    logic [63:0] v = '0;
    v[0] = ie; v[1] = u; v[2] = s; v[3] = h;
    v[16:11] = up; v[9:4] = lo;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [1:0] s);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk);
    reg_wr = 1'b0; reg_wstrb = 2'b00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic run(input logic [1:0] p, input int n);
    @(negedge clk);
    priv = p;
    repeat (n) @(negedge clk);
    priv = 2'd3;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 64'h0);
    rd(A_CNT, v);  check("R1 counts", v, 64'h0);
    rd(A_STAT, v); check("R1 status", v, 64'h0);
    check("R1 irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_layout();
    logic [63:0] v;
    wr(A_CNT, 64'h11223344_55667788, 2'b11);
    rd(A_CNT, v); check("R2 readback", v, 64'h11223344_55667788);
  endtask

  task automatic t_gating();
    logic [63:0] v;
    wr(A_CNT, 64'h0000_0100_0000_0200, 2'b11);
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'd0, 6'd0), 2'b00);
    run(2'd0, 5);
    rd(A_CNT, v); check("R4 R11 user counts", v, 64'h0000_0105_0000_0205);
    run(2'd1, 5);
    rd(A_CNT, v); check("R4 sup disabled", v, 64'h0000_0105_0000_0205);
    run(2'd3, 4);
    rd(A_CNT, v); check("R4 no context", v, 64'h0000_0105_0000_0205);
    wr(A_CTRL, mk_ctrl(0, 0, 1, 1, 6'd0, 6'd0), 2'b00);
    run(2'd2, 3);
    rd(A_CNT, v); check("R4 hyp counts", v, 64'h0000_0108_0000_0208);
    run(2'd0, 3);
    rd(A_CNT, v); check("R4 user now off", v, 64'h0000_0108_0000_0208);
    wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 6'd0, 6'd0), 2'b00);
    run(2'd1, 3);
    rd(A_CNT, v); check("R4 all enables clear", v, 64'h0000_0108_0000_0208);
  endtask

  task automatic t_select();
    logic [63:0] v;
    wr(A_CNT, 64'h0, 2'b11);
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'd5, 6'd7), 2'b00);
    @(negedge clk);
    priv = 2'd0; evt_in = '0; evt_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    evt_in = '0; evt_in[7] = 1'b1;
    repeat (2) @(negedge clk);
    priv = 2'd3; evt_in = '0;
    rd(A_CNT, v); check("R5 selected lines", v, 64'h0000_0004_0000_0002);
  endtask

  task automatic t_park();
    logic [63:0] v;
    wr(A_CNT, 64'h0, 2'b11);
    evt_in = '1;
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'h1C, 6'h1C), 2'b00);
    run(2'd0, 6);
    rd(A_CNT, v); check("R6 upper parked on 1C", v, 64'h0000_0000_0000_0006);
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'h14, 6'h14), 2'b00);
    run(2'd0, 6);
    rd(A_CNT, v); check("R6 lower parked on 14", v, 64'h0000_0006_0000_0006);
    evt_in = '0;
  endtask

  task automatic t_halves();
    logic [63:0] v;
    wr(A_CNT, 64'hAAAA_0000_BBBB_0000, 2'b11);
    wr(A_CNT, 64'h1234_5678_CCCC_0001, 2'b01);
    rd(A_CNT, v); check("R7 lower only", v, 64'hAAAA_0000_CCCC_0001);
    wr(A_CNT, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00);
    rd(A_CNT, v); check("R7 no strobe", v, 64'hAAAA_0000_CCCC_0001);
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'd0, 6'd0), 2'b00);
    @(negedge clk);
    priv = 2'd0; reg_wr = 1'b1; reg_addr = A_CNT; reg_wstrb = 2'b10;
    reg_wdata = 64'h5000_0000_7777_7777;
    @(negedge clk);
    reg_wr = 1'b0; reg_wstrb = 2'b00; priv = 2'd3;
    rd(A_CNT, v); check("R7 R8 write wins, other counts", v, 64'h5000_0000_CCCC_0002);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    wr(A_CTRL, mk_ctrl(1, 1, 0, 0, 6'd0, 6'd0), 2'b00);
    wr(A_CNT, 64'hFFFF_FFFD_0000_0010, 2'b11);
    run(2'd0, 2);
    rd(A_STAT, v); check("R3 no flag before wrap", v, 64'h0);
    check("R10 irq low before wrap", {63'h0, irq}, 64'h0);
    run(2'd0, 1);
    rd(A_CNT, v); check("R3 upper wrapped to 0", v, 64'h0000_0000_0000_0013);
    check("R3 bit31 clear after wrap", {63'h0, v[63]}, 64'h0);
    rd(A_STAT, v); check("R3 upper flag", v, 64'h1);
    check("R10 irq raised", {63'h0, irq}, 64'h1);
    wr(A_CTRL, mk_ctrl(0, 1, 0, 0, 6'd0, 6'd0), 2'b00);
    #1 check("R10 irq masked", {63'h0, irq}, 64'h0);
    rd(A_STAT, v); check("R9 flag kept while masked", v, 64'h1);
    wr(A_CTRL, mk_ctrl(1, 1, 0, 0, 6'd0, 6'd0), 2'b00);
    #1 check("R10 irq unmasked", {63'h0, irq}, 64'h1);
    wr(A_STAT, 64'h2, 2'b00);
    rd(A_STAT, v); check("R9 other bit write no effect", v, 64'h1);
    wr(A_STAT, 64'h1, 2'b00);
    rd(A_STAT, v); check("R9 w1c clears", v, 64'h0);
    check("R10 irq drops", {63'h0, irq}, 64'h0);
    wr(A_CNT, 64'h0000_0000_FFFF_FFFF, 2'b11);
    run(2'd0, 1);
    rd(A_CNT, v); check("R3 lower wrapped", v, 64'h0000_0001_0000_0000);
    rd(A_STAT, v); check("R3 lower flag", v, 64'h2);
    check("R10 irq from lower", {63'h0, irq}, 64'h1);
    wr(A_STAT, 64'h3, 2'b00);
    rd(A_STAT, v); check("R9 clear both", v, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_gating();
    t_select();
    t_park();
    t_halves();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule